// File: doc/BRIEF.md
# Lane-Parallel Tree Sum Reducer

This block adds up an integer stream of arbitrary length. Rather than folding every element into one running total, which would put a loop-carried adder on every element, it keeps one running partial sum per lane. Elements arrive in chunks, one element per lane. Each accepted chunk is added into the partials lane by lane, so a whole chunk costs one cycle. When the chunk flagged as final has been taken in, the block collapses the partials pairwise. On each collapse cycle the active width halves and every lower lane takes in its partner from the upper half. After log2(LANES) such cycles, lane 0 holds the total.

The controller has three named states:
- `VR_ACCUM`: the block accepts chunks with `in_ready` high.
- `VR_FOLD`: the block runs the halving steps with `in_ready` low.
- `VR_EMIT`: the block presents the total for one cycle and clears all partials.

The transitions are:
- **accept-final**: `VR_ACCUM` to `VR_FOLD`, on a handshake with `in_last` high. When LANES is 1, this goes straight to `VR_EMIT`.
- **fold-done**: `VR_FOLD` to `VR_EMIT`, after the last halving step.
- **rearm**: `VR_EMIT` to `VR_ACCUM`, always after one cycle.

A user streams chunks with `in_valid` and `in_last`, then waits for the single-cycle `out_valid` pulse. The next stream may start on the cycle after that pulse. All sums wrap modulo 2^DATA_W in two's complement.

Top module: `vec_tree_reducer`

## Requirements
- R1: While reset is active, and after it is released, `in_ready` is 1, `out_valid` is 0 and `out_sum` is 0.
- R2: A chunk is accepted on a rising edge where both `in_valid` and `in_ready` are 1. Element k of a chunk is bits [k*DATA_W +: DATA_W] of `in_data`, and it is added into partial k.
- R3: `in_ready` is 0 from the edge that accepts the final chunk until `out_valid` has dropped. Chunks offered during that window are not added to any sum.
- R4: `out_valid` goes high exactly log2(LANES) rising edges after the edge that accepted the final chunk. With the default of 8 lanes, that is the third edge.
- R5: `out_valid` stays high for exactly one cycle. `out_sum` is 0 whenever `out_valid` is 0. On the cycle after the pulse, `in_ready` is 1 again.
- R6: The partials are cleared when the result is delivered. Each stream's total therefore counts only the chunks of that stream.
- R7: The total, and every intermediate partial, wraps modulo 2^DATA_W in two's complement. For example, four full chunks of 0x7FFF in 8 lanes give 0xFFE0.
- R8: A stream made of a single chunk, flagged final, yields the sum of that chunk's elements.
- R9: A cycle with `in_valid` at 0 leaves every partial unchanged, whatever value `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A chunk is offered |
| in_ready | output | 1 | The block can accept a chunk |
| in_last | input | 1 | The offered chunk ends the stream |
| in_data | input | LANES*DATA_W | Chunk, lane k in bits [k*DATA_W +: DATA_W] |
| out_valid | output | 1 | Total is present this cycle |
| out_sum | output | DATA_W | Stream total, zero when not valid |

## Verification
Two functions share a cycle on the edge that accepts the final chunk. On that edge, the last lane-wise add and the switch into the halving sequence both happen, so the total must already include that chunk. Single-chunk streams and back-to-back final chunks provoke this, and the bench judges it by comparing the total against a bench-side wrapped sum. A second overlap is the delivery cycle, where the partials are cleared while the source keeps offering garbage chunks. The bench holds `in_valid` high with random data throughout the halving and delivery cycles. It then checks that the following stream's total is unaffected and that `in_ready` returns on the exact expected cycle.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic [1:0] {
        VR_ACCUM = 2'd0,
        VR_FOLD  = 2'd1,
        VR_EMIT  = 2'd2
    } vred_state_e;

endpackage

// File: rtl/vred_lanes.sv
module vred_lanes #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SW     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    fold_en,
    input  logic                    clr,
    input  logic [SW-1:0]           step,
    input  logic [LANES*DATA_W-1:0] chunk,
    output logic [LANES*DATA_W-1:0] part_flat,
    output logic [DATA_W-1:0]       lane0
);

    localparam int unsigned LIW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [DATA_W-1:0] part_q [LANES];
    logic [DATA_W-1:0] part_d [LANES];

    always_comb begin
        int half;
        half = int'(LANES) >> (int'(step) + 1);
        for (int i = 0; i < int'(LANES); i++) begin
            logic [LIW-1:0] mate;
            mate = LIW'((i + half) % int'(LANES));
            part_d[i] = part_q[i];
            if (clr) begin
                part_d[i] = '0;
            end else if (acc_en) begin
                part_d[i] = part_q[i] + chunk[i*DATA_W +: DATA_W];
            end else if (fold_en && (i < half)) begin
                part_d[i] = part_q[i] + part_q[mate];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(LANES); i++) begin
            if (!rst_n) part_q[i] <= '0;
            else        part_q[i] <= part_d[i];
        end
    end

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_flat
            assign part_flat[g*DATA_W +: DATA_W] = part_q[g];
        end
    endgenerate

    assign lane0 = part_q[0];

endmodule

// File: rtl/vred_ctrl.sv
module vred_ctrl
    import vred_pkg::*;
#(
    parameter int unsigned STEPS = 3,
    parameter int unsigned SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic          out_valid,
    output logic          acc_en,
    output logic          fold_en,
    output logic          clr,
    output logic [SW-1:0] step
);

    localparam logic [SW-1:0] LAST_STEP = SW'((STEPS > 0) ? STEPS - 1 : 0);

    vred_state_e   st_q, st_d;
    logic [SW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= VR_ACCUM;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions: accept-final, fold-done, rearm
    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        unique case (st_q)
            VR_ACCUM: begin
                if (in_valid && in_last) st_d = (STEPS == 0) ? VR_EMIT : VR_FOLD;
            end
            VR_FOLD: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST_STEP) begin
                    st_d  = VR_EMIT;
                    cnt_d = '0;
                end
            end
            VR_EMIT: st_d = VR_ACCUM;
            default: st_d = VR_ACCUM;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (st_q == VR_ACCUM);
        acc_en    = (st_q == VR_ACCUM) && in_valid;
        fold_en   = (st_q == VR_FOLD);
        out_valid = (st_q == VR_EMIT);
        clr       = (st_q == VR_EMIT);
        step      = cnt_q;
    end

    // R5
    emit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3
    stall_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R3
    no_ready_on_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R5
    ready_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> in_ready);

endmodule

// File: rtl/vec_tree_reducer.sv
module vec_tree_reducer
    import vred_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_last,
    input  logic [LANES*DATA_W-1:0] in_data,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_sum
);

    localparam int unsigned STEPS = $clog2(LANES);
    localparam int unsigned SW    = (STEPS > 0) ? STEPS : 1;

    logic                    acc_en, fold_en, clr;
    logic [SW-1:0]           step;
    logic [LANES*DATA_W-1:0] part_flat;
    logic [DATA_W-1:0]       lane0;

    vred_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .acc_en    (acc_en),
        .fold_en   (fold_en),
        .clr       (clr),
        .step      (step)
    );

    vred_lanes #(.LANES(LANES), .DATA_W(DATA_W), .SW(SW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .fold_en   (fold_en),
        .clr       (clr),
        .step      (step),
        .chunk     (in_data),
        .part_flat (part_flat),
        .lane0     (lane0)
    );

    assign out_sum = out_valid ? lane0 : '0;

    // R6
    cleared_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (part_flat == '0));

    // R9
    idle_keeps_parts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(part_flat));

    // R5
    sum_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_sum == '0));

endmodule

// File: tb/tb_vec_tree_reducer.sv
`timescale 1ns/1ps
module tb_vec_tree_reducer;

    localparam int LANES  = 8;
    localparam int DW     = 16;
    localparam int STEPS  = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_last = 1'b0;
    logic [LANES*DW-1:0]  in_data = '0;
    logic                 in_ready;
    logic                 out_valid;
    logic [DW-1:0]        out_sum;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vec_tree_reducer #(.LANES(LANES), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_last(in_last), .in_data(in_data), .out_valid(out_valid), .out_sum(out_sum)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] chunk_sum(input logic [LANES*DW-1:0] c);
        logic [DW-1:0] s = '0;
        for (int k = 0; k < LANES; k++) s = s + c[k*DW +: DW];
        return s;
    endfunction

    function automatic logic [LANES*DW-1:0] make_chunk(input int mode);
        logic [LANES*DW-1:0] c;
        for (int k = 0; k < LANES; k++) begin
            case (mode)
                1:       c[k*DW +: DW] = 16'h7FFF;
                2:       c[k*DW +: DW] = 16'hFFFF;
                3:       c[k*DW +: DW] = DW'(k + 1);
                default: c[k*DW +: DW] = DW'($urandom);
            endcase
        end
        return c;
    endfunction

    function automatic logic [LANES*DW-1:0] junk();
        logic [LANES*DW-1:0] c;
        for (int k = 0; k < LANES; k++) c[k*DW +: DW] = DW'($urandom);
        return c;
    endfunction

    task automatic reduce(input int nchunks, input int mode, input int maxgap, input string tag);
        logic [DW-1:0]       expv = '0;
        logic [LANES*DW-1:0] c;
        for (int n = 0; n < nchunks; n++) begin
            int gap = (maxgap > 0) ? int'($urandom_range(maxgap)) : 0;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = junk();       // R9: idle data must not count
            end
            @(negedge clk);
            check(in_ready === 1'b1, {"R2 ready during accumulation ", tag}, in_ready, 1);
            c = make_chunk(mode);
            in_valid = 1'b1;
            in_data  = c;
            in_last  = (n == nchunks - 1);
            expv     = expv + chunk_sum(c);
            @(posedge clk);
        end
        for (int t = 0; t <= STEPS; t++) begin
            @(negedge clk);
            check(out_valid === (t == STEPS), {"R4 result timing ", tag}, out_valid, (t == STEPS));
            check(in_ready === 1'b0, {"R3 stalled ", tag}, in_ready, 0);
            if (t == STEPS)
                check(out_sum === expv, {"R2 R7 R8 total ", tag}, out_sum, expv);
            in_valid = 1'b1;             // R3: offered chunks are ignored
            in_last  = 1'($urandom);
            in_data  = junk();
        end
        @(negedge clk);
        check(out_valid === 1'b0, {"R5 pulse width ", tag}, out_valid, 0);
        check(in_ready === 1'b1, {"R5 ready returns ", tag}, in_ready, 1);
        check(out_sum === '0, {"R5 quiet sum ", tag}, out_sum, 0);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1 in reset", {in_ready, out_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
        check(out_valid === 1'b0, "R1 no result after reset", out_valid, 0);
        check(out_sum === '0, "R1 sum zero after reset", out_sum, 0);

        reduce(1, 3, 0, "R8 single ramp");          // 1+..+8 = 36
        reduce(1, 0, 0, "R8 single random");
        reduce(4, 1, 0, "R7 max positive wrap");    // 0xFFE0
        reduce(3, 2, 1, "R7 minus one");            // 0xFFE8
        reduce(2, 3, 3, "R9 gaps");
        reduce(1, 1, 0, "R6 after wrap");
        for (int r = 0; r < 30; r++)
            reduce(1 + int'($urandom_range(5)), 0, 2, "random");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule